// File: doc/BRIEF.md
# Chaining DMA Register and Sequencing Controller

This block holds the software-visible registers of a bus-mastering DMA engine and the small state machine that walks a transfer from arming to completion. Software programs a control word, a local (memory-side) start address, a byte count and finally the bus address. Writing the bus address arms the engine. The controller then raises a transfer request towards a master sequencer and pulses a start strobe towards the memory side. It counts data phases until the byte count runs out, then posts a terminal-count status that can raise an interrupt.

In chaining mode, software first loads address/count pairs into a descriptor queue and then sets the chain bit. The controller pulls one pair at a time into its counters and runs each block in turn. It reports completion only after the last queued block. When the master side stops a block early, the controller waits until both the master and the memory side are idle, then requests again with whatever count is left.

Top module: `chain_dma_regs`

## Requirements
- R1: After reset every register reads zero, and `irq`, `xfer_req` and `mem_start` are low.
- R2: Register offsets are: control 0x00, bus address 0x04, byte count 0x08, status 0x0C, local address 0x10. The descriptor queue is written at any address with bit 19 set.
  - Control bits: 0 interrupt enable, 1 flush (always reads 0), 3 direction, 4 DMA enable, 5 completion-interrupt disable, 6 running (read only), 8 chain enable. Bits 2 and 7 read 0.
  - The bus address is held in bits 31:2 and bits 1:0 read 0. The byte count is held in bits 16:2 and all other bits read 0.
  - The local address is write only and reads 0. The status register ignores writes.
  - Status bits: 0 interrupt pending, 1 error pending, 2 interrupt request, 3 terminal count, 4 address loaded, 5 chain start.
- R3: A bus-address write sets address loaded and clears terminal count. One cycle later the running bit sets, provided DMA enable is 1 and no error is pending.
- R4: While running, `xfer_req` is high, and `mem_start` pulses for one cycle when the request begins. Each `xfer_beat` adds 4 to the bus address and to `mem_addr`, and subtracts 4 from the byte count.
- R5: The beat that takes the count to zero ends the transfer. Terminal count and interrupt pending set, address loaded and running clear, and `xfer_req` drops.
- R6: Terminal count clears on a read of the status register, on a control write, or on a bus-address write.
- R7: `irq` equals interrupt pending AND interrupt enable. Interrupt pending is (terminal count AND NOT completion-interrupt disable) OR error pending.
- R8: A control write with the flush bit set empties the descriptor queue and clears address loaded and chain start. A chain bit in the same write does not set chain start.
- R9: A control write with chain enable set sets chain start. Queued pairs (address word first, then count word) are loaded and run one after another. Terminal count sets, and chain start clears, only when a block ends with the queue empty.
- R10: `xfer_stop` before the final beat drops `xfer_req`. The request returns, with a new `mem_start` pulse and the remaining count, only once `mst_busy` and `mem_busy` are both low.
- R11: Error pending follows `err_in` one cycle later. While it is set, arming is blocked and any running transfer is abandoned.
- R12: `xfer_dir` follows control bit 3 (1 = memory to bus).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register or descriptor write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | ADDR_W | Byte address within the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| xfer_req | output | 1 | Request to the master sequencer |
| xfer_dir | output | 1 | Direction, 1 = memory to bus |
| xfer_addr | output | 32 | Current bus address |
| xfer_beat | input | 1 | One data phase completed |
| xfer_stop | input | 1 | Master ended the block early |
| mst_busy | input | 1 | Master side still active |
| mem_start | output | 1 | One-cycle start strobe to the memory side |
| mem_addr | output | LA_W+2 | Current local address |
| mem_busy | input | 1 | Memory side still active |
| err_in | input | 1 | Bus error status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the hand-over from one chained block to the next. It needs a queue holding several pairs, a block that ends exactly on its last beat, and a check that terminal count stays clear at that point while chain start stays set. The stimulus queues two pairs of different lengths, enables chaining, and drives beats only while the request is high. It checks the bus address at the start of each block and the status word between blocks. A second hard case is an early stop with staggered release of the two busy inputs: the bench frees the master first and confirms that the request stays low until the memory side is freed as well.

// File: rtl/chain_dma_regs.sv
module chain_dma_regs #(
  parameter int ADDR_W     = 20,
  parameter int DESC_DEPTH = 256,
  parameter int BA_W       = 30,
  parameter int BC_W       = 15,
  parameter int LA_W       = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              xfer_req,
  output logic              xfer_dir,
  output logic [31:0]       xfer_addr,
  input  logic              xfer_beat,
  input  logic              xfer_stop,
  input  logic              mst_busy,
  output logic              mem_start,
  output logic [LA_W+1:0]   mem_addr,
  input  logic              mem_busy,
  input  logic              err_in,
  output logic              irq
);
  localparam int PW = $clog2(DESC_DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_FETCH_A, S_FETCH_C, S_RUN, S_HOLD} st_t;
  st_t state;

  logic            int_en, dir, dma_en, tc_dis, chain_en;
  logic            dma_on, tc, ad_loaded, chain_start, err_pend;
  logic [BA_W-1:0] acr;
  logic [BC_W-1:0] bcr;
  logic [LA_W-1:0] lar;
  logic [31:0]     dq [DESC_DEPTH];
  logic [PW:0]     wp, rp;

  wire reg_sel  = !reg_addr[ADDR_W-1] && (reg_addr[ADDR_W-2:5] == '0);
  wire wr_ctl   = reg_wr && reg_sel && reg_addr[4:0] == 5'h00;
  wire wr_acr   = reg_wr && reg_sel && reg_addr[4:0] == 5'h04;
  wire wr_bcr   = reg_wr && reg_sel && reg_addr[4:0] == 5'h08;
  wire wr_lar   = reg_wr && reg_sel && reg_addr[4:0] == 5'h10;
  wire rd_isr   = reg_rd && reg_sel && reg_addr[4:0] == 5'h0C;
  wire wr_desc  = reg_wr && reg_addr[ADDR_W-1];

  wire q_empty  = wp == rp;
  wire q_full   = (wp[PW] != rp[PW]) && (wp[PW-1:0] == rp[PW-1:0]);
  wire [31:0] q_head = dq[rp[PW-1:0]];

  wire last     = (state == S_RUN) && (bcr == '0 || (xfer_beat && bcr == BC_W'(1)));
  wire more     = chain_en && !q_empty;
  wire int_pend = (tc && !tc_dis) || err_pend;

  assign irq       = int_pend && int_en;
  assign xfer_req  = state == S_RUN;
  assign xfer_dir  = dir;
  assign xfer_addr = 32'(acr) << 2;
  assign mem_addr  = {lar, 2'b00};

  always_comb begin
    reg_rdata = '0;
    if (reg_sel)
      case (reg_addr[4:0])
        5'h00: reg_rdata = {23'd0, chain_en, 1'b0, dma_on, tc_dis, dma_en, dir, 2'b00, int_en};
        5'h04: reg_rdata = 32'(acr) << 2;
        5'h08: reg_rdata = 32'(bcr) << 2;
        5'h0C: reg_rdata = {26'd0, chain_start, ad_loaded, tc, irq, err_pend, int_pend};
        default: reg_rdata = '0;
      endcase
  end

  always_ff @(posedge clk)
    if (wr_desc && !q_full) dq[wp[PW-1:0]] <= reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      {int_en, dir, dma_en, tc_dis, chain_en} <= '0;
      {dma_on, tc, ad_loaded, chain_start, err_pend, mem_start} <= '0;
      acr <= '0; bcr <= '0; lar <= '0; wp <= '0; rp <= '0;
    end else begin
      mem_start <= 1'b0;
      err_pend  <= err_in;
      if (wr_desc && !q_full) wp <= wp + 1'b1;
      if (rd_isr) tc <= 1'b0;
      if (wr_bcr) bcr <= reg_wdata[BC_W+1:2];
      if (wr_lar) lar <= reg_wdata[LA_W+1:2];
      if (wr_acr) begin
        acr <= reg_wdata[BA_W+1:2];
        ad_loaded <= 1'b1;
        tc <= 1'b0;
      end
      if (wr_ctl) begin
        {chain_en, tc_dis, dma_en, dir, int_en} <=
          {reg_wdata[8], reg_wdata[5], reg_wdata[4], reg_wdata[3], reg_wdata[0]};
        tc <= 1'b0;
        if (reg_wdata[1]) begin
          wp <= '0; rp <= '0;
          ad_loaded <= 1'b0;
          chain_start <= 1'b0;
        end else if (reg_wdata[8]) chain_start <= 1'b1;
      end

      case (state)
        S_IDLE:
          if (ad_loaded && dma_en && !err_pend) begin
            dma_on <= 1'b1; mem_start <= 1'b1; state <= S_RUN;
          end else if (chain_start && dma_en && !err_pend && !q_empty) state <= S_FETCH_A;
        S_FETCH_A: begin
          acr <= q_head[BA_W+1:2]; rp <= rp + 1'b1; state <= S_FETCH_C;
        end
        S_FETCH_C: begin
          bcr <= q_head[BC_W+1:2]; rp <= rp + 1'b1; ad_loaded <= 1'b1; state <= S_IDLE;
        end
        S_RUN: begin
          if (xfer_beat && bcr != '0) begin
            acr <= acr + 1'b1; bcr <= bcr - 1'b1; lar <= lar + 1'b1;
          end
          if (last) begin
            dma_on <= 1'b0; ad_loaded <= 1'b0; state <= S_IDLE;
            if (!more) begin tc <= 1'b1; chain_start <= 1'b0; end
          end else if (xfer_stop) state <= S_HOLD;
        end
        S_HOLD:
          if (!mst_busy && !mem_busy) begin mem_start <= 1'b1; state <= S_RUN; end
        default: state <= S_IDLE;
      endcase

      if (err_pend && (state == S_RUN || state == S_HOLD)) begin
        dma_on <= 1'b0; ad_loaded <= 1'b0; state <= S_IDLE;
      end
    end
  end
endmodule

module chain_dma_regs_chk #(parameter int ADDR_W = 20) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              xfer_req,
  input logic              mem_start,
  input logic              dma_on,
  input logic              ad_loaded,
  input logic              tc
);
  wire hit_lo  = !reg_addr[ADDR_W-1] && (reg_addr[ADDR_W-2:5] == '0);
  wire acr_wr  = reg_wr && hit_lo && reg_addr[4:0] == 5'h04;
  wire isr_rd  = reg_rd && hit_lo && reg_addr[4:0] == 5'h0C;

  assert_arm_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_on) |-> $past(ad_loaded));
  assert_acr_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acr_wr && !dma_on) |=> ad_loaded);
  assert_req_while_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> dma_on);
  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start |=> !mem_start);
  assert_tc_from_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> $past(dma_on));
  assert_stop_drops_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_on) |-> !xfer_req);
  assert_isr_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd && !dma_on) |=> !tc);
endmodule

bind chain_dma_regs chain_dma_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .xfer_req(xfer_req), .mem_start(mem_start), .dma_on(dma_on),
  .ad_loaded(ad_loaded), .tc(tc)
);

// File: tb/chain_dma_regs_test.sv
module chain_dma_regs_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [19:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, xfer_addr;
  logic xfer_req, xfer_dir, xfer_beat = 0, xfer_stop = 0, mst_busy = 0;
  logic mem_start, mem_busy = 0, err_in = 0, irq;
  logic [25:0] mem_addr;
  int n_vec = 0, n_bad = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  chain_dma_regs uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rdc(input logic [19:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, tag, d, exp);
  endtask

  task automatic beat();
    xfer_beat = 1; @(negedge clk); xfer_beat = 0;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 12; i++) if (!xfer_req) @(negedge clk);
  endtask

  // {write, addr, data, expected read}
  localparam logic [84:0] VEC [10] = '{
    {1'b1, 20'h00000, 32'h0000_00AD, 32'h0},
    {1'b0, 20'h00000, 32'h0,         32'h0000_0029},
    {1'b1, 20'h00004, 32'h1234_5677, 32'h0},
    {1'b0, 20'h00004, 32'h0,         32'h1234_5674},
    {1'b1, 20'h00008, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 20'h00008, 32'h0,         32'h0001_FFFC},
    {1'b1, 20'h00010, 32'h0AAA_AAAA, 32'h0},
    {1'b0, 20'h00010, 32'h0,         32'h0},
    {1'b1, 20'h0000C, 32'h0000_00FF, 32'h0},
    {1'b0, 20'h0000C, 32'h0,         32'h0000_0010}
  };

  initial begin
    #(20 * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rdc(20'h00, 0, "R1 ctl"); rdc(20'h04, 0, "R1 acr");
    rdc(20'h08, 0, "R1 bcr"); rdc(20'h0C, 0, "R1 isr");
    chk(!irq && !xfer_req && !mem_start, "R1 outputs", {irq, xfer_req, mem_start}, 0);

    // R2 register map vectors
    foreach (VEC[i]) begin
      if (VEC[i][84]) wr(VEC[i][83:64], VEC[i][63:32]);
      else rdc(VEC[i][83:64], VEC[i][31:0], "R2 map");
    end
    chk(mem_addr == 26'h2AAAAA8, "R2 lar field", 32'(mem_addr), 32'h2AAAAA8);
    chk(xfer_dir == 1, "R12 dir set", 32'(xfer_dir), 1);
    wr(20'h00, 32'h02);
    chk(xfer_dir == 0, "R12 dir clear", 32'(xfer_dir), 0);
    rdc(20'h0C, 0, "R8 flush clears address loaded");

    // R3 R4 R5 single block
    wr(20'h00, 32'h11); wr(20'h08, 8); wr(20'h10, 32'h100); wr(20'h04, 32'h2000);
    rdc(20'h00, 32'h11, "R3 not yet on");
    chk(xfer_req && mem_start, "R4 request and start", {xfer_req, mem_start}, 3);
    rdc(20'h00, 32'h51, "R3 running bit");
    beat();
    rdc(20'h04, 32'h2004, "R4 acr step"); rdc(20'h08, 4, "R4 bcr step");
    chk(mem_addr == 26'h104, "R4 lar step", 32'(mem_addr), 32'h104);
    beat();
    chk(!xfer_req && irq, "R5 done", {xfer_req, irq}, 1);
    rdc(20'h0C, 32'h0D, "R5 status");
    chk(!irq, "R6 isr read clears", 32'(irq), 0);

    // R6 control write clears
    wr(20'h08, 4); wr(20'h04, 32'h3000); wait_req(); beat();
    chk(irq, "R6 tc set again", 32'(irq), 1);
    wr(20'h00, 32'h11);
    chk(!irq, "R6 ctl write clears", 32'(irq), 0);

    // R6 acr write clears, R11 error blocks arming
    wr(20'h08, 4); wr(20'h04, 32'h3000); wait_req(); beat();
    err_in = 1; @(negedge clk);
    wr(20'h04, 32'h5000);
    repeat (3) @(negedge clk);
    chk(!xfer_req, "R11 blocked", 32'(xfer_req), 0);
    rdc(20'h0C, 32'h17, "R6 R11 status");
    wr(20'h00, 32'h13); err_in = 0;
    repeat (3) @(negedge clk);
    chk(!xfer_req && !irq, "R11 cleared", {xfer_req, irq}, 0);

    // R7 completion interrupt disable
    wr(20'h00, 32'h31); wr(20'h08, 4); wr(20'h04, 32'h6000); wait_req(); beat();
    rdc(20'h0C, 32'h08, "R7 tc without pending");
    chk(!irq, "R7 irq masked", 32'(irq), 0);
    wr(20'h00, 32'h11);

    // R10 early stop and resume
    mst_busy = 1; mem_busy = 1;
    wr(20'h08, 12); wr(20'h04, 32'h7000); wait_req(); beat();
    xfer_stop = 1; @(negedge clk); xfer_stop = 0;
    chk(!xfer_req, "R10 stop drops", 32'(xfer_req), 0);
    mst_busy = 0; @(negedge clk);
    chk(!xfer_req && !mem_start, "R10 wait memory", {xfer_req, mem_start}, 0);
    mem_busy = 0; @(negedge clk);
    chk(xfer_req && mem_start, "R10 resume", {xfer_req, mem_start}, 3);
    rdc(20'h08, 8, "R10 remaining count"); rdc(20'h04, 32'h7004, "R10 address kept");
    beat(); beat();
    chk(!xfer_req && irq, "R10 completes", {xfer_req, irq}, 1);

    // R8 flush
    wr(20'h00, 32'h02);
    wr(20'h80000, 32'h9000); wr(20'h80000, 4);
    wr(20'h00, 32'h100);
    rdc(20'h0C, 32'h20, "R8 chain start set");
    wr(20'h00, 32'h102);
    rdc(20'h0C, 0, "R8 flush clears chain start");
    rdc(20'h00, 32'h100, "R8 flush reads zero");
    wr(20'h00, 32'h110);
    repeat (6) @(negedge clk);
    chk(!xfer_req, "R8 queue emptied", 32'(xfer_req), 0);
    wr(20'h00, 32'h02);

    // R9 chaining two blocks
    wr(20'h80000, 32'h4000); wr(20'h80000, 4);
    wr(20'h80004, 32'h8000); wr(20'h80004, 8);
    wr(20'h00, 32'h111);
    wait_req();
    chk(xfer_addr == 32'h4000, "R9 first pair", xfer_addr, 32'h4000);
    beat();
    chk(!irq, "R9 no tc mid chain", 32'(irq), 0);
    rd(20'h0C, v);
    chk((v & 32'h28) == 32'h20, "R9 between blocks", v & 32'h28, 32'h20);
    wait_req();
    chk(xfer_addr == 32'h8000, "R9 second pair", xfer_addr, 32'h8000);
    beat(); beat();
    rdc(20'h0C, 32'h0D, "R9 chain done");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule